// File: doc/BRIEF.md
# Character LCD Parallel Bus Sequencer

This block runs single write and read transfers on the asynchronous parallel bus of an HD44780-style character display, timed entirely by the system clock. A requester presents a direction, a register-select bit and write data. When the block is idle it takes the request and starts a bus cycle. The cycle drives chip select, register select, read/write and a 16-bit data bus. It then pulses the enable strobe and returns. After a programmable chip-select gap it raises a one-cycle done pulse, together with the sampled read data on a read.

Each transfer has three timed phases: setup, strobe and hold. Reads and writes each have their own set of phase lengths. The block selects the set for the request's direction when it accepts the request and latches it. On a read the data bus is released before the strobe starts, and it stays released until a later write takes the bus again. A typical display exchange is a data write followed by a busy-flag status read.

Top module: `lcd_bus_seq`

## Requirements
- R1: `req_ready_o` is 1 exactly when the block is idle. A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. A `req_valid_i` seen while busy is ignored and does not change the running cycle.
- R2: Chip select `lcd_cs_no` (active low) goes low on the accepting edge. `lcd_rs_o` and `lcd_rw_o` take the request values on that same edge and stay stable while chip select is low. The setup phase lasts the selected setup length (0 to 31 cycles).
- R3: `lcd_en_o` is 1 only while chip select is low. It is 1 for exactly the selected strobe length (1 to 63 cycles), starting setup-length cycles after the accepting edge.
- R4: After the strobe, chip select stays low for the selected hold length (1 to 15 cycles). The total time chip select is low is setup + strobe + hold cycles.
- R5: `done_o` is a single-cycle pulse. It comes a chip-select-delay count (0 to 3) of cycles after chip select rises, while the block is idle again.
- R6: During a write, `lcd_d_oe_o` is 1 and `lcd_d_o` carries the request's write data for the whole time chip select is low.
- R7: During a read, `lcd_d_oe_o` is 0 from the accepting edge onward. It stays 0 until the next write is accepted.
- R8: On a read, the value on `lcd_d_i` during the last strobe cycle is captured on the edge that ends the strobe. `rdata_o` holds that value.
- R9: `lcd_rw_o` is 1 for a read and 0 for a write. The read setup/strobe/hold lengths are used for reads and the write lengths for writes, each independently of the other set.
- R10: A strobe or hold setting of 0 behaves as 1.
- R11: After reset, `lcd_cs_no`=1, `lcd_en_o`=0, `lcd_d_oe_o`=0, `done_o`=0, `req_ready_o`=1 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_read_i | input | 1 | 1 = read cycle, 0 = write cycle |
| req_rs_i | input | 1 | Register-select value for the cycle |
| req_wdata_i | input | 16 | Write data |
| wr_setup_i | input | 5 | Write setup length in cycles |
| wr_strobe_i | input | 6 | Write strobe length in cycles |
| wr_hold_i | input | 4 | Write hold length in cycles |
| rd_setup_i | input | 5 | Read setup length in cycles |
| rd_strobe_i | input | 6 | Read strobe length in cycles |
| rd_hold_i | input | 4 | Read hold length in cycles |
| cs_gap_i | input | 2 | Chip-select delay before done, in cycles |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| lcd_cs_no | output | 1 | Chip select, active low |
| lcd_rs_o | output | 1 | Register select |
| lcd_rw_o | output | 1 | Read/write line |
| lcd_en_o | output | 1 | Enable strobe |
| lcd_d_o | output | 16 | Data bus output value |
| lcd_d_oe_o | output | 1 | Data bus output enable |
| lcd_d_i | input | 16 | Data bus input value |

## Verification
All timing is counted from the accepting edge, which is index 0:
- Chip select is low for indices 0 to setup+strobe+hold−1.
- The enable strobe is high from index setup to index setup+strobe−1.
- Read data is taken at index setup+strobe, from the bus value driven after index setup+strobe−1.
- Done is due at index setup+strobe+hold+gap.

The bench samples on the falling edge after every rising edge and tracks the index. It changes `lcd_d_i` after each sample so that the captured value shows which cycle was sampled. It compares the first, last and count of each window against these formulas. It also checks the sample after done to confirm the pulse lasts one cycle.

// File: rtl/lcd_bus_pkg.sv
`timescale 1ns/1ps
package lcd_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } phase_e;
endpackage

// File: rtl/lcd_seq_fsm.sv
`timescale 1ns/1ps
module lcd_seq_fsm
  import lcd_bus_pkg::*;
#(
  parameter int SU_W  = 5,
  parameter int STB_W = 6,
  parameter int HLD_W = 4,
  parameter int GAP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [SU_W-1:0]  wr_su_i,
  input  logic [STB_W-1:0] wr_stb_i,
  input  logic [HLD_W-1:0] wr_hld_i,
  input  logic [SU_W-1:0]  rd_su_i,
  input  logic [STB_W-1:0] rd_stb_i,
  input  logic [HLD_W-1:0] rd_hld_i,
  input  logic [GAP_W-1:0] gap_i,
  output phase_e           phase_o,
  output logic             strobe_last_o,
  output logic             done_o
);
  localparam int W_A   = (SU_W > STB_W) ? SU_W : STB_W;
  localparam int W_B   = (HLD_W > GAP_W) ? HLD_W : GAP_W;
  localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [STB_W-1:0] stb_q;
  logic [HLD_W-1:0] hld_q;
  logic [GAP_W-1:0] gap_q;

  logic [SU_W-1:0]  su_sel;
  logic [STB_W-1:0] stb_sel;
  logic [HLD_W-1:0] hld_sel;
  logic             last;

  // zero strobe/hold is treated as one cycle
  always_comb begin
    su_sel  = rd_i ? rd_su_i : wr_su_i;
    stb_sel = rd_i ? rd_stb_i : wr_stb_i;
    hld_sel = rd_i ? rd_hld_i : wr_hld_i;
    if (stb_sel == '0) stb_sel = STB_W'(1);
    if (hld_sel == '0) hld_sel = HLD_W'(1);
  end

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      stb_q   <= '0;
      hld_q   <= '0;
      gap_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          stb_q <= stb_sel;
          hld_q <= hld_sel;
          gap_q <= gap_i;
          if (su_sel == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(stb_sel) - CNT_W'(1);
          end else begin
            phase_q <= PH_SETUP;
            cnt_q   <= CNT_W'(su_sel) - CNT_W'(1);
          end
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_STROBE;
          cnt_q   <= CNT_W'(stb_q) - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_STROBE: if (last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(hld_q) - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_HOLD: if (last) begin
          if (gap_q == '0) begin
            phase_q <= PH_IDLE;
            done_o  <= 1'b1;
          end else begin
            phase_q <= PH_GAP;
            cnt_q   <= CNT_W'(gap_q) - CNT_W'(1);
          end
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_GAP: if (last) begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o       = phase_q;
  assign strobe_last_o = (phase_q == PH_STROBE) && last;

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phase_q == PH_IDLE));
  a_r1_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && !last) |=> (phase_q == PH_HOLD));
endmodule

// File: rtl/lcd_bus_io.sv
`timescale 1ns/1ps
module lcd_bus_io #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_read_i,
  input  logic              req_rs_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              rs_o,
  output logic              rw_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_o    <= 1'b0;
      rw_o    <= 1'b1;
      bus_o   <= '0;
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (start_i) begin
        rs_o <= req_rs_i;
        rw_o <= req_read_i;
        oe_o <= !req_read_i;
        if (!req_read_i) bus_o <= req_wdata_i;
      end
      if (capture_i && rw_o) rdata_o <= bus_i;
    end
  end
endmodule

// File: rtl/lcd_bus_seq.sv
`timescale 1ns/1ps
module lcd_bus_seq
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SU_W   = 5,
  parameter int STB_W  = 6,
  parameter int HLD_W  = 4,
  parameter int GAP_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_read_i,
  input  logic              req_rs_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [SU_W-1:0]   wr_setup_i,
  input  logic [STB_W-1:0]  wr_strobe_i,
  input  logic [HLD_W-1:0]  wr_hold_i,
  input  logic [SU_W-1:0]   rd_setup_i,
  input  logic [STB_W-1:0]  rd_strobe_i,
  input  logic [HLD_W-1:0]  rd_hold_i,
  input  logic [GAP_W-1:0]  cs_gap_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lcd_cs_no,
  output logic              lcd_rs_o,
  output logic              lcd_rw_o,
  output logic              lcd_en_o,
  output logic [DATA_W-1:0] lcd_d_o,
  output logic              lcd_d_oe_o,
  input  logic [DATA_W-1:0] lcd_d_i
);
  phase_e phase;
  logic   start, strobe_last;

  assign req_ready_o = (phase == PH_IDLE);
  assign start       = req_valid_i && req_ready_o;

  lcd_seq_fsm #(
    .SU_W(SU_W), .STB_W(STB_W), .HLD_W(HLD_W), .GAP_W(GAP_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .start_i       (start),
    .rd_i          (req_read_i),
    .wr_su_i       (wr_setup_i),
    .wr_stb_i      (wr_strobe_i),
    .wr_hld_i      (wr_hold_i),
    .rd_su_i       (rd_setup_i),
    .rd_stb_i      (rd_strobe_i),
    .rd_hld_i      (rd_hold_i),
    .gap_i         (cs_gap_i),
    .phase_o       (phase),
    .strobe_last_o (strobe_last),
    .done_o        (done_o)
  );

  lcd_bus_io #(.DATA_W(DATA_W)) u_io (
    .clk_i, .rst_ni,
    .start_i     (start),
    .req_read_i  (req_read_i),
    .req_rs_i    (req_rs_i),
    .req_wdata_i (req_wdata_i),
    .capture_i   (strobe_last),
    .bus_i       (lcd_d_i),
    .rs_o        (lcd_rs_o),
    .rw_o        (lcd_rw_o),
    .bus_o       (lcd_d_o),
    .oe_o        (lcd_d_oe_o),
    .rdata_o     (rdata_o)
  );

  assign lcd_en_o  = (phase == PH_STROBE);
  assign lcd_cs_no = !(phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);

  a_r3_en_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> !lcd_cs_no);
  a_r2_ctrl_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_cs_no && $past(!lcd_cs_no)) |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o)));
  a_r7_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_cs_no && lcd_rw_o) |-> !lcd_d_oe_o);
  a_r6_write_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_cs_no && !lcd_rw_o) |-> lcd_d_oe_o);
  a_r1_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !lcd_cs_no && $past(!lcd_cs_no)) |=> $stable(lcd_rs_o));
endmodule

// File: tb/lcd_bus_seq_tb.sv
`timescale 1ns/1ps
module lcd_bus_seq_tb;
  typedef struct packed {
    logic        rd;
    logic        rs;
    logic [15:0] wd;
    logic [4:0]  su;
    logic [5:0]  stb;
    logic [3:0]  hld;
    logic [1:0]  gap;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 16'h0041,  5'd2,  6'd4, 4'd2, 2'd1},
    '{1'b1, 1'b0, 16'h0000,  5'd1,  6'd3, 4'd1, 2'd0},
    '{1'b0, 1'b1, 16'hBEEF,  5'd0,  6'd1, 4'd1, 2'd0},
    '{1'b1, 1'b1, 16'h0000,  5'd0,  6'd1, 4'd1, 2'd3},
    '{1'b0, 1'b0, 16'h1234, 5'd31, 6'd63, 4'd15, 2'd3},
    '{1'b1, 1'b0, 16'h0000, 5'd31, 6'd63, 4'd15, 2'd2},
    '{1'b0, 1'b0, 16'hC0DE,  5'd3,  6'd0, 4'd0, 2'd0},
    '{1'b1, 1'b1, 16'h0000,  5'd2,  6'd0, 4'd0, 2'd1}
  };

  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, req_read_i = 0, req_rs_i = 0;
  logic [15:0] req_wdata_i = 0, lcd_d_i = 0;
  logic [4:0]  wr_setup_i = 0, rd_setup_i = 0;
  logic [5:0]  wr_strobe_i = 1, rd_strobe_i = 1;
  logic [3:0]  wr_hold_i = 1, rd_hold_i = 1;
  logic [1:0]  cs_gap_i = 0;
  logic        req_ready_o, done_o, lcd_cs_no, lcd_rs_o, lcd_rw_o, lcd_en_o, lcd_d_oe_o;
  logic [15:0] rdata_o, lcd_d_o;

  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  lcd_bus_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit bogus);
    int k, su, stb, hld, tot, en_cnt, en_first, en_last, cs_cnt, cs_last, done_k;
    bit ctl_bad, bus_bad, oe_bad, ready_bad;
    logic [15:0] exp_rd;
    su = int'(v.su); stb = (v.stb == 0) ? 1 : int'(v.stb);
    hld = (v.hld == 0) ? 1 : int'(v.hld); tot = su + stb + hld;
    // other direction gets unrelated lengths (R9)
    if (v.rd) begin
      rd_setup_i = v.su; rd_strobe_i = v.stb; rd_hold_i = v.hld;
      wr_setup_i = 5'd7; wr_strobe_i = 6'd9; wr_hold_i = 4'd5;
    end else begin
      wr_setup_i = v.su; wr_strobe_i = v.stb; wr_hold_i = v.hld;
      rd_setup_i = 5'd11; rd_strobe_i = 6'd2; rd_hold_i = 4'd6;
    end
    cs_gap_i = v.gap; req_read_i = v.rd; req_rs_i = v.rs; req_wdata_i = v.wd;
    req_valid_i = 1;
    en_cnt = 0; en_first = -1; en_last = -1; cs_cnt = 0; cs_last = -1; done_k = -1;
    ctl_bad = 0; bus_bad = 0; oe_bad = 0; ready_bad = 0;
    k = 0;
    @(posedge clk_i);
    while (1) begin
      @(negedge clk_i);
      if (lcd_en_o) begin
        en_cnt++; en_last = k;
        if (en_first < 0) en_first = k;
      end
      if (!lcd_cs_no) begin
        cs_cnt++; cs_last = k;
        if (lcd_rs_o !== v.rs || lcd_rw_o !== v.rd) ctl_bad = 1;
        if (!v.rd && (lcd_d_o !== v.wd || lcd_d_oe_o !== 1'b1)) bus_bad = 1;
        if (v.rd && lcd_d_oe_o !== 1'b0) oe_bad = 1;
        if (req_ready_o !== 1'b0) ready_bad = 1;
      end
      if (done_o) done_k = k;
      lcd_d_i = 16'h5A00 + 16'(k);
      if (k == 0) begin
        req_valid_i = bogus; req_rs_i = ~v.rs; req_read_i = ~v.rd;
      end else req_valid_i = 0;
      if (done_k >= 0 || k > 400) break;
      k++;
    end
    chk(ctl_bad == 0, "R2 rs/rw held during cycle", int'(ctl_bad), 0);
    chk(cs_cnt == tot && cs_last == tot - 1, "R4 cs low length", cs_cnt, tot);
    chk(en_cnt == stb && en_first == su && en_last == su + stb - 1,
        "R3 strobe window start", en_first, su);
    chk(en_cnt == stb, v.stb == 0 ? "R10 zero strobe as one" : "R9 strobe length", en_cnt, stb);
    chk(done_k == tot + int'(v.gap), "R5 done index", done_k, tot + int'(v.gap));
    chk(ready_bad == 0, "R1 busy while cs low", int'(ready_bad), 0);
    chk(req_ready_o === 1'b1, "R1 ready at done", int'(req_ready_o), 1);
    if (v.rd) begin
      exp_rd = 16'h5A00 + 16'(su + stb - 1);
      chk(oe_bad == 0, "R7 bus released on read", int'(oe_bad), 0);
      chk(rdata_o === exp_rd, "R8 read capture", int'(rdata_o), int'(exp_rd));
    end else
      chk(bus_bad == 0, "R6 write data driven", int'(bus_bad), 0);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R5 done single cycle", int'(done_o), 0);
    if (v.rd) chk(lcd_d_oe_o === 1'b0, "R7 released after read", int'(lcd_d_oe_o), 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20;
    // R11 reset state
    chk(lcd_cs_no === 1'b1, "R11 cs idle", int'(lcd_cs_no), 1);
    chk(lcd_en_o === 1'b0, "R11 en low", int'(lcd_en_o), 0);
    chk(lcd_d_oe_o === 1'b0, "R11 oe low", int'(lcd_d_oe_o), 0);
    chk(done_o === 1'b0 && req_ready_o === 1'b1, "R11 done/ready", int'(done_o), 0);
    chk(rdata_o === 16'h0, "R11 rdata", int'(rdata_o), 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) run(VECS[i], i[0]);
    // R7: oe stays low across idle after a read, then write retakes the bus
    repeat (5) @(negedge clk_i);
    chk(lcd_d_oe_o === 1'b0, "R7 idle after read", int'(lcd_d_oe_o), 0);
    // typical exchange: data write then status read
    run('{1'b0, 1'b1, 16'h0048, 5'd1, 6'd2, 4'd1, 2'd0}, 1'b0);
    chk(lcd_d_oe_o === 1'b1, "R6 oe kept after write", int'(lcd_d_oe_o), 1);
    run('{1'b1, 1'b0, 16'h0000, 5'd1, 6'd2, 4'd1, 2'd0}, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule